// File: doc/BRIEF.md
# Byte-Lane Enable Data Path

This block models the data-bus side of a 16-bit asynchronous memory word store that has two active-low byte-lane selects. One select covers the low eight bits and the other covers the high eight bits. Every control strobe, the address and the write data are first brought into a fast sampling clock domain. A state machine then decodes the sampled strobes into one of five named states: `ST_STANDBY`, `ST_SELECTED`, `ST_READ`, `ST_WRITE` and `ST_WRITE_DONE`.

On a read, the block presents only the selected lanes. Each lane has its own output-enable pin, so the tristate buffer can sit outside the block. On a write, the block updates only the lanes that were selected in the addressed word. The update takes place once per write cycle, at the first sampled rising edge of chip select, write strobe, low-lane select or high-lane select. The data stored is the last value sampled before that edge.

The transitions are as follows:
- Chip select high leads to `ST_STANDBY`.
- With chip select low and both lane selects high, the state is `ST_SELECTED`. The bus is idle but the device stays selected.
- With write strobe low and a lane selected, the state is `ST_WRITE`. When a commit edge arrives, it moves to `ST_WRITE_DONE`.
- `ST_WRITE_DONE` holds until the decoded access stops being a write.
- With write strobe high, output enable low and a lane selected, the state is `ST_READ`.

Top module: `bytelane_sram`

## Requirements
- R1: After reset, both lane output enables are 0, `dq_out` is 0 and every stored word reads back as 0.
- R2: A read (`ce_n`=0, `we_n`=1, `oe_n`=0) with both `lb_n` and `ub_n` low sets both lane enables and presents the whole stored word on `dq_out`.
- R3: In a read with one lane select high, that lane's enable is 0 and its eight bits of `dq_out` are 0 (low lane = bits 7:0 under `lb_n`, high lane = bits 15:8 under `ub_n`), while the other lane shows stored data.
- R4: No lane is driven while `oe_n` is high or `we_n` is low; with both `we_n` and `oe_n` low the access is a write.
- R5: With `ce_n` low and both lane selects high, no lane is driven and a write strobe stores nothing.
- R6: A write commits at the first sampled rise of `ce_n`, `we_n`, `lb_n` or `ub_n`, and stores the data and address sampled just before that rise.
- R7: A write leaves unchanged the lane whose select was high during the write.
- R8: Only the first commit edge in a write cycle stores data; later lane-select rises in the same cycle, with new data, leave the word unchanged.
- R9: With `ce_n` high, nothing is driven and no write is stored, whatever the other strobes do.
- R10: With two synchronizer stages, lane enables and read data follow a change at the pins on the third rising clock edge after it.
- R11: Several strobes rising in the same sample cycle produce one commit of the pre-edge data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low-lane select (bits 7:0), active low |
| ub_n | input | 1 | High-lane select (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Data arriving from the bus |
| dq_out | output | 2*LANE_W | Data to present on the bus; undriven lanes read 0 |
| dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15:8 |

## Verification
A change at the pins passes two synchronizer flops and one output register, so read results are due after the third rising edge. The bench changes pins on a falling edge and samples four falling edges later, except in one latency check that samples exactly after the second and third edges. A write commits on the third edge after the strobe rise. The bench lets it settle for four cycles and only then reads the word back through a read access, comparing against a bench-side memory image built from the lane selects of each write.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_SELECTED,
        ST_READ,
        ST_WRITE,
        ST_WRITE_DONE
    } bl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
    } bl_strobe_t;

    localparam int BL_LANES    = 2;
    localparam int BL_STROBE_W = $bits(bl_strobe_t);

endpackage

// File: rtl/bytelane_sync.sv
module bytelane_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/bytelane_ctrl.sv
module bytelane_ctrl
    import bytelane_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = BL_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bl_strobe_t        strb,
    input  logic [WORD_W-1:0] rd_data,
    output bl_state_e         state_q,
    output logic              commit,
    output logic              capture,
    output logic [BL_LANES-1:0] drive,
    output logic [WORD_W-1:0] dq_q
);

    bl_state_e             decoded;
    bl_state_e             state_d;
    logic [3:0]            cur;
    logic [3:0]            prev_q;
    logic [3:0]            rise;
    logic [BL_LANES-1:0]   lane_sel;

    assign lane_sel = {~strb.ub_n, ~strb.lb_n};
    assign cur      = {strb.ce_n, strb.we_n, strb.ub_n, strb.lb_n};
    assign rise     = cur & ~prev_q;
    assign commit   = (state_q == ST_WRITE) && (rise != 4'b0000);
    assign capture  = (state_d == ST_WRITE);

    // access decode: write strobe wins over output enable
    always_comb begin
        if (strb.ce_n)              decoded = ST_STANDBY;
        else if (lane_sel == '0)    decoded = ST_SELECTED;
        else if (!strb.we_n)        decoded = ST_WRITE;
        else if (!strb.oe_n)        decoded = ST_READ;
        else                        decoded = ST_SELECTED;
    end

    always_comb begin
        unique case (decoded)
            ST_STANDBY:    state_d = ST_STANDBY;
            ST_SELECTED:   state_d = ST_SELECTED;
            ST_READ:       state_d = ST_READ;
            ST_WRITE:      state_d = (commit || state_q == ST_WRITE_DONE)
                                     ? ST_WRITE_DONE : ST_WRITE;
            ST_WRITE_DONE: state_d = ST_WRITE_DONE;
            default:       state_d = ST_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            prev_q  <= 4'b1111;
        end else begin
            state_q <= state_d;
            prev_q  <= cur;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= '0;
            dq_q  <= '0;
        end else begin
            for (int l = 0; l < BL_LANES; l++) begin
                drive[l] <= (state_d == ST_READ) && lane_sel[l];
                dq_q[l*LANE_W +: LANE_W] <= ((state_d == ST_READ) && lane_sel[l])
                                            ? rd_data[l*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/bytelane_store.sv
module bytelane_store
    import bytelane_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 8,
    localparam int WORD_W = BL_LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                commit,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [BL_LANES-1:0] in_lane,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data
);

    logic [ADDR_W-1:0]   cap_addr;
    logic [WORD_W-1:0]   cap_data;
    logic [BL_LANES-1:0] cap_lane;

    // hold the last sample seen during an open write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_lane <= '0;
        end else if (capture) begin
            cap_addr <= in_addr;
            cap_data <= in_data;
            cap_lane <= in_lane;
        end
    end

    for (genvar g = 0; g < BL_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (commit && cap_lane[g]) begin
                mem[cap_addr] <= cap_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
    import bytelane_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = BL_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi
);

    localparam int BUS_W = ADDR_W + WORD_W;

    bl_strobe_t          strb_raw;
    bl_strobe_t          strb_s;
    logic [BUS_W-1:0]    bus_s;
    logic [ADDR_W-1:0]   addr_s;
    logic [WORD_W-1:0]   data_s;
    logic [WORD_W-1:0]   rd_data;
    bl_state_e           ctrl_state;
    logic                wr_commit;
    logic                wr_capture;
    logic [BL_LANES-1:0] drive;

    assign strb_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, ub_n: ub_n, lb_n: lb_n};

    bytelane_sync #(
        .W      (BL_STROBE_W),
        .STAGES (SYNC_STAGES),
        .RST    ({BL_STROBE_W{1'b1}})
    ) u_sync_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strb_raw),
        .q     (strb_s)
    );

    bytelane_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST    ('0)
    ) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, dq_in}),
        .q     (bus_s)
    );

    assign addr_s = bus_s[BUS_W-1 -: ADDR_W];
    assign data_s = bus_s[WORD_W-1:0];

    bytelane_ctrl #(
        .LANE_W (LANE_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb_s),
        .rd_data (rd_data),
        .state_q (ctrl_state),
        .commit  (wr_commit),
        .capture (wr_capture),
        .drive   (drive),
        .dq_q    (dq_out)
    );

    bytelane_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (wr_capture),
        .commit  (wr_commit),
        .in_addr (addr_s),
        .in_data (data_s),
        .in_lane ({~strb_s.ub_n, ~strb_s.lb_n}),
        .rd_addr (addr_s),
        .rd_data (rd_data)
    );

    assign dq_oe_lo = drive[0];
    assign dq_oe_hi = drive[1];

endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk
    import bytelane_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input bl_state_e                  state,
    input logic                       commit,
    input logic [BL_LANES-1:0]        drive,
    input logic [BL_LANES*LANE_W-1:0] dq_out
);

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != '0) |-> (state == ST_READ)); // R4

    AST_LO_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !drive[0] |-> (dq_out[LANE_W-1:0] == '0)); // R3

    AST_HI_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !drive[1] |-> (dq_out[2*LANE_W-1:LANE_W] == '0)); // R3

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state != ST_WRITE)); // R8

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY) |-> (drive == '0)); // R9

    AST_NO_IDLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_WRITE_DONE || state == ST_STANDBY
                    || state == ST_SELECTED || state == ST_READ)); // R6

endmodule

bind bytelane_sram bytelane_sram_chk #(.LANE_W(LANE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (ctrl_state),
    .commit (wr_commit),
    .drive  ({dq_oe_hi, dq_oe_lo}),
    .dq_out (dq_out)
);

// File: tb/bytelane_sram_tb.sv
module bytelane_sram_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] img [16];

    always #(CLK_P/2) clk = ~clk;

    bytelane_sram u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
    );

    function automatic logic [15:0] pat(input int a);
        return {8'(a * 37 + 17), 8'((a * 91) ^ 8'hC3)};
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic c, w, o, l, u, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; dq_in = d;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_sel(input logic [3:0] a);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, a, 16'h0); settle();
    endtask

    task automatic read_chk(input logic [3:0] a, input logic l, input logic u, input string tag);
        logic [17:0] exp;
        apply(1'b0, 1'b1, 1'b0, l, u, a, 16'h0); settle();
        exp = {~u, ~l, (u ? 8'h00 : img[a][15:8]), (l ? 8'h00 : img[a][7:0])};
        check(tag, {dq_oe_hi, dq_oe_lo, dq_out}, exp);
    endtask

    task automatic write_word(input logic [3:0] a, input logic [15:0] d, input logic l, input logic u);
        idle_sel(a);
        apply(1'b0, 1'b0, 1'b1, l, u, a, d); settle();
        apply(1'b0, 1'b1, 1'b1, l, u, a, d); settle();
        if (!l) img[a][7:0]  = d[7:0];
        if (!u) img[a][15:8] = d[15:8];
        idle_sel(a);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) img[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 reset outputs", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
        read_chk(4'd5, 1'b0, 1'b0, "R1 reset content");
        idle_sel(4'd0);

        // R10: latency of the read path, two sync stages plus output register
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0);
        repeat (2) @(negedge clk);
        check("R10 not yet driven after two edges", {16'h0, dq_oe_hi, dq_oe_lo}, 18'h0);
        @(negedge clk);
        check("R10 driven after third edge", {16'h0, dq_oe_hi, dq_oe_lo}, 18'h3);
        idle_sel(4'd0);

        // R2/R3: full-word fill then sweep of lane selections
        for (int a = 0; a < 16; a++) write_word(4'(a), pat(a), 1'b0, 1'b0);
        for (int a = 0; a < 16; a++) begin
            read_chk(4'(a), 1'b0, 1'b0, "R2 full read");
            read_chk(4'(a), 1'b0, 1'b1, "R3 low lane only");
            read_chk(4'(a), 1'b1, 1'b0, "R3 high lane only");
        end

        // R7: single-lane writes keep the other lane
        for (int a = 0; a < 16; a++) begin
            write_word(4'(a), ~pat(a), (a % 2 == 1), (a % 2 == 0));
            read_chk(4'(a), 1'b0, 1'b0, "R7 unselected lane kept");
        end

        // R4: oe high, then we low with oe low
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 16'h0); settle();
        check("R4 oe high no drive", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 16'hBEEF); settle();
        check("R4 write wins over oe", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 16'hBEEF); settle();
        img[2] = 16'hBEEF;
        check("R4 write stored then read", {dq_oe_hi, dq_oe_lo, dq_out}, {2'b11, 16'hBEEF});
        idle_sel(4'd2);

        // R5: both lane selects high
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4, 16'h0); settle();
        check("R5 lanes off no drive", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, 16'h1234); settle();
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd4, 16'h1234); settle();
        read_chk(4'd4, 1'b0, 1'b0, "R5 lanes off no write");

        // R6: last data before a chip-select rise is stored
        idle_sel(4'd6);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 16'h1111); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 16'h2222); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 16'h3333); settle();
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 16'h3333); settle();
        img[6] = 16'h3333;
        read_chk(4'd6, 1'b0, 1'b0, "R6 commit on chip select rise");

        // R6: high-lane select rise commits while write strobe stays low
        idle_sel(4'd7);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7, 16'hAAAA); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 16'h5555); settle();
        img[7][15:8] = 8'hAA;
        idle_sel(4'd7);
        read_chk(4'd7, 1'b0, 1'b0, "R6 commit on lane select rise");

        // R8: second lane rise in the same write cycle stores nothing
        idle_sel(4'd8);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 16'hA1B2); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 16'hA1B2); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 16'hC3D4); settle();
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8, 16'hC3D4); settle();
        img[8] = 16'hA1B2;
        idle_sel(4'd8);
        read_chk(4'd8, 1'b0, 1'b0, "R8 single commit per cycle");

        // R11: all strobes rise together
        idle_sel(4'd9);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9, 16'h5566); settle();
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9, 16'h5566); settle();
        img[9] = 16'h5566;
        read_chk(4'd9, 1'b0, 1'b0, "R11 simultaneous rise one commit");

        // R9: chip deselected
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 16'h0); settle();
        check("R9 deselected no drive", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 16'hFFFF); settle();
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 16'hFFFF); settle();
        read_chk(4'd3, 1'b0, 1'b0, "R9 deselected no write");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule